// File: doc/BRIEF.md
# Cascadable Sequential Configuration Memory Reader

This block is the read side of a sequential-access memory that feeds a stored configuration image to a loader. The loader supplies the clock. While the device is selected and out of reset, each clock steps an internal pointer through the stored image. The current item is presented either as one bit on data lane 0 (serial mode) or as a whole byte on all eight lanes (byte mode). A new item appears just after a rising clock edge, so the receiver can sample it on the next rising edge.

Several devices can share one data bus and one clock. The chain-enable output of each device drives the chip-enable of the next. When a device has given out its last item, the next advancing clock turns its own bus drive off and pulls its chain-enable output low, and the next device then takes the bus. The pointer never wraps. It stays parked past the end until the reset/output-enable pin is taken to its reset level, and that level is chosen by a parameter. A busy input freezes both the pointer and the data. A parameter can tie busy off inside the block. The storage array is written through a simple synchronous write port, which the surrounding system or a testbench uses to preload the image.

Top module: `seqcfg_reader`

## Requirements
- R1: On a rising clock edge the read pointer advances by one item only when chip-enable is active (`ce_n`=0), the reset/OE pin is at its output-enable level, busy is not in effect, and the end of the image has not yet been passed.
- R2: While the reset/OE pin is at its reset level, the pointer is held at item 0 (byte 0, bit 7), the end-passed state is cleared, `dout_en` is 0, `dout` reads 8'h00 and `chain_en_n` is 1.
- R3: With RST_ACT_LOW=0 the reset level of `rst_oe` is 1. With RST_ACT_LOW=1 the reset level is 0.
- R4: With `ce_n`=1 the pointer is frozen, `standby` is 1, `dout_en` is 0 and `dout` reads 8'h00, whatever the level of `rst_oe`.
- R5: After the last item has been passed, further clocks do not move the pointer. Data stays disabled until a reset.
- R6: `chain_en_n` is 0 exactly when chip-enable is active, OE is active and the end has been passed. After that it follows `ce_n` for as long as OE stays active.
- R7: The clock edge that advances beyond the last item drives `chain_en_n` low and `dout_en` low together. The two are never active at the same time.
- R8: In serial mode (`par_mode`=0), lane 0 carries the bits of each byte MSB first (bit 7 down to bit 0), and bytes are read in ascending address order. Lanes 7..1 read 0.
- R9: In byte mode (`par_mode`=1), `dout[7:0]` carries one whole stored byte per clock, in ascending address order.
- R10: While `busy`=1 the pointer and the data are held. With BUSY_IGNORE=1 the busy pin has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock from the loader |
| ce_n | input | 1 | Chip-enable, active low |
| rst_oe | input | 1 | Reset/output-enable pin, polarity set by RST_ACT_LOW |
| busy | input | 1 | Hold request: freezes pointer and data |
| par_mode | input | 1 | 0 = serial on lane 0, 1 = byte-wide |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | AW | Preload byte address |
| wr_data | input | 8 | Preload byte |
| dout | output | 8 | Data lanes, zero when not driving |
| dout_en | output | 1 | Bus drive enable (0 = high-impedance) |
| chain_en_n | output | 1 | Chip-enable for the next device, active low |
| standby | output | 1 | High while chip-enable is inactive |

## Verification
Two functions can coincide on one edge: the busy hold and the end-of-image handoff. The bench therefore walks the pointer to the last serial bit and raises busy on exactly the cycle that would otherwise pass the end. It then expects the last bit to stay on the bus with `chain_en_n` high. On the following edge, with busy low, it expects `dout_en` to fall and `chain_en_n` to fall in the same cycle. A reference model in the bench predicts every post-edge output word, and a scoreboard compares each predicted word with the sampled outputs one nanosecond after the edge.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
   localparam int BYTE_W  = 8;
   localparam int BIT_IW  = 3;
   localparam logic [BIT_IW-1:0] FIRST_BIT = 3'd7;

   typedef enum logic {
      MODE_SERIAL = 1'b0,
      MODE_BYTE   = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/cfgrd_store.sv
module cfgrd_store
   import cfgrd_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [BYTE_W-1:0] rd_data
);
   logic [BYTE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/cfgrd_seq.sv
module cfgrd_seq
   import cfgrd_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              hold,
   input  logic              step_ok,
   input  rd_mode_e          mode,
   output logic [AW-1:0]     addr,
   output logic [BIT_IW-1:0] bit_idx,
   output logic              past_tc
);
   localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

   logic at_last;
   assign at_last = (addr == LAST_ADDR) &&
                    ((mode == MODE_BYTE) || (bit_idx == '0));

   always_ff @(posedge clk or posedge hold) begin
      if (hold) begin
         addr    <= '0;
         bit_idx <= FIRST_BIT;
         past_tc <= 1'b0;
      end else if (step_ok && !past_tc) begin
         if (at_last) begin
            past_tc <= 1'b1;
         end else if (mode == MODE_BYTE || bit_idx == '0) begin
            addr    <= addr + 1'b1;
            bit_idx <= FIRST_BIT;
         end else begin
            bit_idx <= bit_idx - 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfgrd_outmux.sv
module cfgrd_outmux
   import cfgrd_pkg::*;
(
   input  logic              drive,
   input  rd_mode_e          mode,
   input  logic [BYTE_W-1:0] word,
   input  logic [BIT_IW-1:0] bit_idx,
   output logic [BYTE_W-1:0] lanes
);
   genvar k;
   generate
      for (k = 0; k < BYTE_W; k++) begin : g_lane
         if (k == 0) begin : g_first
            assign lanes[k] = drive &
               ((mode == MODE_BYTE) ? word[0] : word[bit_idx]);
         end else begin : g_rest
            assign lanes[k] = drive & (mode == MODE_BYTE) & word[k];
         end
      end
   endgenerate
endmodule

// File: rtl/seqcfg_reader.sv
module seqcfg_reader
   import cfgrd_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter bit RST_ACT_LOW = 1'b0,
   parameter bit BUSY_IGNORE = 1'b0,
   parameter int AW          = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              ce_n,
   input  logic              rst_oe,
   input  logic              busy,
   input  logic              par_mode,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] dout,
   output logic              dout_en,
   output logic              chain_en_n,
   output logic              standby
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("seqcfg_reader: DEPTH must be at least 2");
      end
      if (AW < $clog2(DEPTH)) begin : g_bad_aw
         $error("seqcfg_reader: AW too narrow for DEPTH");
      end
   endgenerate

   logic hold, oe_act, ce_act, busy_eff, step_ok, past_tc;
   logic [AW-1:0]     addr;
   logic [BIT_IW-1:0] bit_idx;
   logic [BYTE_W-1:0] word;
   rd_mode_e          mode;

   generate
      if (RST_ACT_LOW) begin : g_rst_low
         assign hold = ~rst_oe;
      end else begin : g_rst_high
         assign hold = rst_oe;
      end
      if (BUSY_IGNORE) begin : g_busy_off
         assign busy_eff = 1'b0;
      end else begin : g_busy_on
         assign busy_eff = busy;
      end
   endgenerate

   assign oe_act  = ~hold;
   assign ce_act  = ~ce_n;
   assign mode    = rd_mode_e'(par_mode);
   assign step_ok = ce_act & oe_act & ~busy_eff;

   cfgrd_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (addr),
      .rd_data (word)
   );

   cfgrd_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
      .clk     (clk),
      .hold    (hold),
      .step_ok (step_ok),
      .mode    (mode),
      .addr    (addr),
      .bit_idx (bit_idx),
      .past_tc (past_tc)
   );

   assign dout_en    = ce_act & oe_act & ~past_tc;
   assign chain_en_n = ~(ce_act & oe_act & past_tc);
   assign standby    = ~ce_act;

   cfgrd_outmux u_out (
      .drive   (dout_en),
      .mode    (mode),
      .word    (word),
      .bit_idx (bit_idx),
      .lanes   (dout)
   );
endmodule

// File: rtl/cfgrd_chk.sv
module cfgrd_chk
   import cfgrd_pkg::*;
#(
   parameter bit RST_ACT_LOW = 1'b0,
   parameter bit BUSY_IGNORE = 1'b0
) (
   input logic              clk,
   input logic              ce_n,
   input logic              rst_oe,
   input logic              busy,
   input logic              par_mode,
   input logic              wr_en,
   input logic [BYTE_W-1:0] dout,
   input logic              dout_en,
   input logic              chain_en_n,
   input logic              standby
);
   logic in_rst, hold_req;
   assign in_rst   = RST_ACT_LOW ? ~rst_oe : rst_oe;
   assign hold_req = busy & ~BUSY_IGNORE;

   AST_RESET_QUIET: assert property (@(posedge clk)
      in_rst |-> (!dout_en && chain_en_n && dout == '0)); // R2

   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (in_rst)
      ce_n |-> (standby && !dout_en && dout == '0)); // R4

   AST_CHAIN_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (in_rst)
      !chain_en_n |-> !ce_n); // R6

   AST_CHAIN_STICKY: assert property (@(posedge clk) disable iff (in_rst)
      (!ce_n && $past(!chain_en_n)) |-> !chain_en_n); // R6

   AST_NO_BUS_OVERLAP: assert property (@(posedge clk) disable iff (in_rst)
      !(dout_en && !chain_en_n)); // R7

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (in_rst)
      (hold_req && dout_en && !wr_en) |=>
      (!dout_en || par_mode != $past(par_mode) || dout == $past(dout))); // R10
endmodule

bind seqcfg_reader cfgrd_chk #(
   .RST_ACT_LOW (RST_ACT_LOW),
   .BUSY_IGNORE (BUSY_IGNORE)
) chk (
   .clk        (clk),
   .ce_n       (ce_n),
   .rst_oe     (rst_oe),
   .busy       (busy),
   .par_mode   (par_mode),
   .wr_en      (wr_en),
   .dout       (dout),
   .dout_en    (dout_en),
   .chain_en_n (chain_en_n),
   .standby    (standby)
);

// File: tb/tb_seqcfg_reader.sv
module tb_seqcfg_reader;
   localparam int D  = 8;
   localparam int AW = $clog2(D);

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic ce_n = 1'b0, rst_oe = 1'b1, busy = 1'b0, par_mode = 1'b1;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] dout;
   logic dout_en, chain_en_n, standby;

   logic ce2_n = 1'b1, rst2 = 1'b0, busy2 = 1'b1;
   logic [7:0] dout2;
   logic en2, chain2_n, sb2;

   seqcfg_reader #(.DEPTH(D)) dut (
      .clk(clk), .ce_n(ce_n), .rst_oe(rst_oe), .busy(busy), .par_mode(par_mode),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dout(dout), .dout_en(dout_en), .chain_en_n(chain_en_n), .standby(standby));

   seqcfg_reader #(.DEPTH(D), .RST_ACT_LOW(1'b1), .BUSY_IGNORE(1'b1)) dut2 (
      .clk(clk), .ce_n(ce2_n), .rst_oe(rst2), .busy(busy2), .par_mode(1'b1),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dout(dout2), .dout_en(en2), .chain_en_n(chain2_n), .standby(sb2));

   int total = 0, fails = 0;
   logic [7:0] img [D];
   int m_ptr = 0, m_bit = 7;
   bit m_past = 0;
   logic [10:0] exp_q [$];
   string tag_q [$];

   function automatic logic [7:0] pat(int i);
      return 8'hA5 ^ 8'(i * 37);
   endfunction

   task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h ({dout,en,chain_n,standby})", tag, act, exp);
      end
   endtask

   // driver: applies one cycle of inputs and predicts the outputs after the edge
   task automatic step(input bit c, input bit o, input bit b, input bit m, input string tag);
      logic en, chn;
      logic [7:0] d;
      @(negedge clk);
      ce_n = !c; rst_oe = !o; busy = b; par_mode = m;
      if (!o) begin
         m_ptr = 0; m_bit = 7; m_past = 0;
      end else if (c && !b && !m_past) begin
         if (m_ptr == D-1 && (m || m_bit == 0)) m_past = 1;
         else if (m || m_bit == 0) begin m_ptr++; m_bit = 7; end
         else m_bit--;
      end
      en  = c && o && !m_past;
      chn = !(c && o && m_past);
      d   = !en ? 8'h00 : (m ? img[m_ptr] : {7'b0, img[m_ptr][m_bit]});
      exp_q.push_back({d, en, chn, !c});
      tag_q.push_back(tag);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk); #1;
         if (exp_q.size() > 0)
            check(tag_q.pop_front(), {dout, dout_en, chain_en_n, standby}, exp_q.pop_front());
      end
   end

   initial begin
      #800000;
      fails++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      for (int i = 0; i < D; i++) begin
         img[i] = pat(i);
         @(negedge clk);
         wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(i);
      end
      @(negedge clk); wr_en = 1'b0;

      // R2: held in reset with chip enabled
      step(1, 0, 0, 1, "R2");
      step(1, 0, 0, 1, "R2");
      // R1 / R9: byte mode advance
      for (int i = 0; i < 3; i++) step(1, 1, 0, 1, "R1");
      // R10: busy holds
      step(1, 1, 1, 1, "R10");
      step(1, 1, 1, 1, "R10");
      step(1, 1, 0, 1, "R1");
      // R4: chip disabled, pointer frozen
      step(0, 1, 0, 1, "R4");
      step(0, 1, 0, 1, "R4");
      step(1, 1, 0, 1, "R4");
      // R2: reset brings pointer back
      step(1, 0, 0, 0, "R2");
      // R8: serial stream MSB first, up to the last bit
      for (int i = 0; i < 8*D - 1; i++) step(1, 1, 0, 0, "R8");
      // R10 with R7: busy on the edge that would pass the end
      step(1, 1, 1, 0, "R10");
      step(1, 1, 0, 0, "R7");
      step(1, 1, 0, 0, "R5");
      step(1, 1, 0, 0, "R5");
      // R6: chain follows chip-enable once past the end
      step(0, 1, 0, 0, "R6");
      step(1, 1, 0, 0, "R6");
      step(1, 0, 0, 0, "R6");
      // R9 / R5: byte mode full run past the end
      for (int i = 0; i < D + 3; i++) step(1, 1, 0, 1, "R9");
      step(1, 0, 0, 1, "R2");
      @(negedge clk); @(negedge clk);

      // R3 / R10: second instance, active-low reset, busy ignored
      rst2 = 1'b0; ce2_n = 1'b0; busy2 = 1'b1;
      @(posedge clk); #1;
      check("R3", {dout2, en2, chain2_n, sb2}, {8'h00, 1'b0, 1'b1, 1'b0});
      @(negedge clk); rst2 = 1'b1;
      @(posedge clk); #1;
      check("R3", {dout2, en2, chain2_n, sb2}, {img[1], 1'b1, 1'b1, 1'b0});
      @(posedge clk); #1;
      check("R10", {dout2, en2, chain2_n, sb2}, {img[2], 1'b1, 1'b1, 1'b0});

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule